// File: doc/BRIEF.md
# Serial Step-Attenuator Programmer

This controller sits on the host side of a three-wire link to a digital step attenuator. A client asks for an attenuation setting as a count of quarter-dB steps and names a 3-bit target address. The request arrives over a valid/ready handshake. The block then does four things:

- It turns the request into a 16-bit frame.
- It shifts the frame out on a data line and a generated serial clock.
- It pulses a latch-enable line so that the receiver transfers the shifted word.
- It raises a single-cycle completion pulse.

All serial timing is expressed in cycles of the system clock. The high time, the low time, the data setup and hold margins and the latch pulse width all equal one half-period parameter, `HALF_CYC`. At the default of 5 cycles with a 100 MHz system clock, the serial clock runs at 10 MHz with 50 ns phases.

A pacing option stops the next request from being taken too soon after the previous update. It is useful when the receiver biases its switches from an internal negative supply and can only be stepped at 25 kHz. The spacing is set by `GAP_CYC`, and the default of 4000 cycles is 40 us at 100 MHz.

Top module: `atten_serial_prog`

## Requirements
- R1: After reset, `ser_clk`, `ser_data`, `ser_latch` and `done` are low and `req_ready` is high.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the cycle that carries `done`, and it is low whenever `ser_clk` or `ser_latch` is high.
- R3: The first frame byte is the attenuation byte:
  - Bits 6..0 hold `req_qdb`, the quarter-dB step count, so 18.25 dB is sent as 73.
  - Any `req_qdb` above 127 is sent as 127.
  - Bit 7 is always 0.
- R4: The second frame byte is the address byte. Its bits 2..0 equal `req_addr` and its bits 7..3 are 0.
- R5: Each frame has exactly 16 rising edges of `ser_clk`. The receiver samples on the rising edge. The bits go out in this order: attenuation bit 0 up to bit 7, then address bit 0 up to bit 7.
- R6: Every high phase and every low phase of `ser_clk` inside a frame lasts exactly `HALF_CYC` system cycles.
- R7: `ser_data` changes only in a cycle where `ser_clk` has just fallen, or in the cycle after a request is taken, while `ser_clk` is low. The bit in place is therefore stable for at least `HALF_CYC` cycles before each rising edge and for `HALF_CYC` cycles after it.
- R8: `ser_latch` stays low while bits are shifting. It rises `2*HALF_CYC` cycles after the 16th rising edge, stays high for `HALF_CYC` cycles, and is never high together with `ser_clk`.
- R9: `done` is high for exactly one cycle, which is the first cycle in which `ser_latch` is low again.
- R10: With `pace_en` low in the `done` cycle, `req_ready` is high in that same cycle. With `pace_en` high, `req_ready` rises exactly `GAP_CYC` cycles after the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_qdb | input | 8 | Attenuation in quarter-dB steps |
| req_addr | input | 3 | Target address |
| pace_en | input | 1 | Enforce minimum spacing after each update |
| ser_clk | output | 1 | Generated serial clock |
| ser_data | output | 1 | Serial data, LSB first |
| ser_latch | output | 1 | Latch-enable pulse transferring the frame |
| done | output | 1 | One-cycle update-complete pulse |

## Verification
The bound checker watches the following on every cycle:
- the exact width of each clock high phase;
- that data moves only just after a falling clock edge;
- that the latch never overlaps the clock and that the 16th rise comes before the latch rises;
- that bit 7 is zero at its rising edge;
- where `done` falls relative to the latch;
- that ready is low while busy.

Some behaviour can only be shown by the bench's frames. This covers the received word rebuilt by a model receiver, the clamping of large requests, the address padding, the low-phase and latch timing measured in cycles, and the exact length of the pacing gap.

// File: rtl/atten_prog_pkg.sv
// Shared types for the serial attenuator programmer.
// Assumes an 8-bit attenuation byte followed by an 8-bit address byte.
package atten_prog_pkg;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_LATCH
    } seq_state_t;

    // Low byte leaves first.
    typedef struct packed {
        logic [BYTE_W-1:0] addr_byte;
        logic [BYTE_W-1:0] atten_byte;
    } frame_t;
endpackage

// File: rtl/atten_frame_build.sv
// Combinational frame assembly.
// Clamps the quarter-dB count to WORD_BITS bits, leaves the upper attenuation
// bits at zero and pads the address into a full byte.
// Assumes REQ_W >= WORD_BITS, WORD_BITS < BYTE_W and ADDR_W <= BYTE_W.
module atten_frame_build
    import atten_prog_pkg::*;
#(
    parameter int REQ_W     = 8,
    parameter int ADDR_W    = 3,
    parameter int WORD_BITS = 7
) (
    input  logic [REQ_W-1:0]  qdb,
    input  logic [ADDR_W-1:0] addr,
    output frame_t            frame
);
    localparam int MAX_CODE = (1 << WORD_BITS) - 1;

    logic [WORD_BITS-1:0] code;

    // Saturate requests beyond the representable range.
    always_comb begin
        if (qdb > REQ_W'(MAX_CODE)) begin
            code = WORD_BITS'(MAX_CODE);
        end else begin
            code = qdb[WORD_BITS-1:0];
        end
    end

    // Place the code and the address into their bytes, upper bits zero.
    always_comb begin
        frame                           = '0;
        frame.atten_byte[WORD_BITS-1:0] = code;
        frame.addr_byte[ADDR_W-1:0]     = addr;
    end
endmodule

// File: rtl/atten_phase_timer.sv
// Half-period timer: raises 'last' every HALF_CYC cycles.
// Restarts from zero on 'restart' so the first phase after a request is full.
module atten_phase_timer #(
    parameter int HALF_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(HALF_CYC - 1));

    // Count cycles within a phase and wrap at the phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/atten_pace_timer.sv
// Update-spacing timer.
// A load arms GAP_CYC cycles of hold; 'hold' stays high until the count
// drains to zero.
module atten_pace_timer #(
    parameter int GAP_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic hold
);
    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt;

    assign hold = (cnt != '0);

    // Load the spacing on completion and count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(GAP_CYC);
        end else if (hold) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/atten_shift_seq.sv
// Frame sequencer.
// Walks lead, high, low, tail and latch phases, each one timer tick long.
// Shifts the frame out LSB first and moves data only on falling clock edges.
// Assumes 'tick' comes from a timer restarted together with 'start'.
module atten_shift_seq
    import atten_prog_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  frame_t frame_in,
    input  logic   tick,
    output logic   idle,
    output logic   finish,
    output logic   ser_clk,
    output logic   ser_data,
    output logic   ser_latch,
    output logic   done
);
    localparam int BIT_CW = $clog2(FRAME_W);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(FRAME_W - 1);

    seq_state_t         state;
    logic [FRAME_W-1:0] sreg;
    logic [BIT_CW-1:0]  bit_cnt;

    assign idle   = (state == ST_IDLE);
    assign finish = (state == ST_LATCH) && tick;

    // Phase sequencing, shift register and registered serial outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sreg      <= '0;
            bit_cnt   <= '0;
            ser_clk   <= 1'b0;
            ser_data  <= 1'b0;
            ser_latch <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sreg     <= frame_in;
                        ser_data <= frame_in[0];
                        bit_cnt  <= '0;
                        state    <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        ser_clk <= 1'b1;
                        state   <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        ser_clk <= 1'b0;
                        if (bit_cnt == LAST_BIT) begin
                            state <= ST_TAIL;
                        end else begin
                            bit_cnt  <= bit_cnt + 1'b1;
                            sreg     <= sreg >> 1;
                            ser_data <= sreg[1];
                            state    <= ST_LOW;
                        end
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        ser_clk <= 1'b1;
                        state   <= ST_HIGH;
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        ser_latch <= 1'b1;
                        state     <= ST_LATCH;
                    end
                end
                ST_LATCH: begin
                    if (tick) begin
                        ser_latch <= 1'b0;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/atten_serial_prog.sv
// Top level of the serial attenuator programmer.
// Takes one request per handshake, builds the frame, runs the sequencer and
// optionally spaces updates.
// Assumes HALF_CYC system cycles meet the receiver's minimum phase time.
module atten_serial_prog
    import atten_prog_pkg::*;
#(
    parameter int HALF_CYC = 5,
    parameter int GAP_CYC  = 4000,
    parameter int REQ_W    = 8,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REQ_W-1:0]  req_qdb,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              pace_en,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch,
    output logic              done
);
    frame_t frame;
    logic   accept;
    logic   tick;
    logic   idle;
    logic   finish;
    logic   hold;

    assign req_ready = idle && !hold;
    assign accept    = req_valid && req_ready;

    atten_frame_build #(
        .REQ_W    (REQ_W),
        .ADDR_W   (ADDR_W),
        .WORD_BITS(BYTE_W - 1)
    ) u_build (
        .qdb  (req_qdb),
        .addr (req_addr),
        .frame(frame)
    );

    atten_phase_timer #(
        .HALF_CYC(HALF_CYC)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(accept),
        .last   (tick)
    );

    atten_shift_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .frame_in (frame),
        .tick     (tick),
        .idle     (idle),
        .finish   (finish),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_latch(ser_latch),
        .done     (done)
    );

    // The spacing timer exists only when a non-zero gap is configured.
    generate
        if (GAP_CYC > 0) begin : g_pace
            atten_pace_timer #(
                .GAP_CYC(GAP_CYC)
            ) u_pace (
                .clk  (clk),
                .rst_n(rst_n),
                .load (finish && pace_en),
                .hold (hold)
            );
        end else begin : g_nopace
            assign hold = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/atten_serial_prog_chk.sv
// Protocol checker for atten_serial_prog, bound to the top.
// Observes ports only and keeps its own run and edge counters.
module atten_serial_prog_chk #(
    parameter int HALF_CYC = 5,
    parameter int GAP_CYC  = 4000
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic pace_en,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_latch,
    input logic done
);
    logic        clk_q;
    logic        latch_q;
    logic [15:0] hi_run;
    logic [4:0]  rise_cnt;

    // Delayed copies and counters: high-phase length, rising edges per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q    <= 1'b0;
            latch_q  <= 1'b0;
            hi_run   <= '0;
            rise_cnt <= '0;
        end else begin
            clk_q   <= ser_clk;
            latch_q <= ser_latch;
            hi_run  <= ser_clk ? hi_run + 1'b1 : '0;
            if (req_valid && req_ready) begin
                rise_cnt <= '0;
            end else if (ser_clk && !clk_q) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk || ser_latch) |-> !req_ready); // R2
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_TOP_ATTEN_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !clk_q && rise_cnt == 5'd7) |-> !ser_data); // R3
    AST_SIXTEEN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_latch && !latch_q) |-> (rise_cnt == 5'd16)); // R5
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_clk && clk_q) |-> (hi_run == 16'(HALF_CYC))); // R6
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data) |-> (!ser_clk && ($past(ser_clk) || $past(req_valid && req_ready)))); // R7
    AST_LATCH_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ser_latch |-> !ser_clk); // R8
    AST_DONE_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ser_latch && latch_q)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    generate
        if (GAP_CYC > 0) begin : g_pace_chk
            AST_PACE_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
                (done && pace_en) |-> !req_ready); // R10
        end
    endgenerate
endmodule

bind atten_serial_prog atten_serial_prog_chk #(
    .HALF_CYC(HALF_CYC),
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .pace_en  (pace_en),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_latch(ser_latch),
    .done     (done)
);

// File: tb/atten_serial_prog_test.sv
`timescale 1ns/1ps
// Bench for atten_serial_prog.
// A model receiver rebuilds each frame from the serial lines and measures
// timing in system cycles. Directed corners are mixed with seeded random
// requests.
module atten_serial_prog_test;
    localparam int HALF = 5;
    localparam int GAP  = 4000;
    localparam int WDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_qdb = '0;
    logic [2:0] req_addr = '0;
    logic       pace_en = 1'b0;
    logic       ser_clk, ser_data, ser_latch, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    atten_serial_prog uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_qdb(req_qdb), .req_addr(req_addr), .pace_en(pace_en),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch(ser_latch), .done(done)
    );

    // Model receiver state and timing error counters.
    logic        p_clk, p_data, p_latch;
    logic [15:0] sr, cap_word;
    int rises, cap_rises, hi_cnt, lo_cnt, le_cnt, since_rise, data_age;
    int err_phase, err_data, err_latch;

    // Sample the serial lines at each falling system-clock edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            p_clk = 0; p_data = 0; p_latch = 0; sr = '0; cap_word = '0;
            rises = 0; cap_rises = 0; hi_cnt = 0; lo_cnt = 0; le_cnt = 0;
            since_rise = 0; data_age = 0;
            err_phase = 0; err_data = 0; err_latch = 0;
        end else begin
            since_rise++;
            if (ser_data != p_data) begin
                if (ser_clk || (rises > 0 && since_rise < HALF)) err_data++;
                data_age = 0;
            end else begin
                data_age++;
            end
            if (ser_clk && !p_clk) begin
                if (data_age < HALF) err_data++;
                if (rises > 0 && lo_cnt != HALF) err_phase++;
                sr = {ser_data, sr[15:1]};
                rises++;
                hi_cnt = 1;
                since_rise = 0;
            end else if (ser_clk) begin
                hi_cnt++;
            end else if (p_clk) begin
                if (hi_cnt != HALF) err_phase++;
                lo_cnt = 1;
            end else begin
                lo_cnt++;
            end
            if (ser_latch && ser_clk) err_latch++;
            if (ser_latch && !p_latch) begin
                if (rises != 16 || since_rise != 2 * HALF) err_latch++;
                cap_word = sr;
                cap_rises = rises;
                le_cnt = 1;
            end else if (ser_latch) begin
                le_cnt++;
            end else if (p_latch) begin
                if (le_cnt != HALF) err_latch++;
                rises = 0;
            end
            p_clk = ser_clk; p_data = ser_data; p_latch = ser_latch;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_atten(input logic [7:0] q);
        return (q > 8'd127) ? 8'd127 : {1'b0, q[6:0]};
    endfunction

    function automatic logic [7:0] exp_addr(input logic [2:0] a);
        return {5'b0, a};
    endfunction

    // Send one request, then check the received frame, timing, done and gap.
    task automatic send(input logic [7:0] q, input logic [2:0] a, input bit pace);
        int e_ph, e_da, e_la, g;
        bit rdy_at_done;
        e_ph = err_phase; e_da = err_data; e_la = err_latch;
        @(negedge clk);
        req_qdb = q; req_addr = a; pace_en = pace; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 ready after accept", req_ready, 0);
        while (!done) @(negedge clk);
        rdy_at_done = req_ready;
        chk(cap_word[7:0] == exp_atten(q), "R3 attenuation byte", cap_word[7:0], exp_atten(q));
        chk(cap_word[15:8] == exp_addr(a), "R4 address byte", cap_word[15:8], exp_addr(a));
        chk(cap_rises == 16, "R5 rising edges", cap_rises, 16);
        chk(err_phase == e_ph, "R6 phase widths", err_phase - e_ph, 0);
        chk(err_data == e_da, "R7 data window", err_data - e_da, 0);
        chk(err_latch == e_la, "R8 latch timing", err_latch - e_la, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done width", done, 0);
        if (rdy_at_done) begin
            g = 0;
        end else begin
            g = 1;
            while (!req_ready) begin
                @(negedge clk);
                g++;
            end
        end
        chk(g == (pace ? GAP : 0), "R10 ready gap", g, pace ? GAP : 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17_C0DE));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_clk == 1'b0, "R1 ser_clk reset", ser_clk, 0);
        chk(ser_data == 1'b0, "R1 ser_data reset", ser_data, 0);
        chk(ser_latch == 1'b0, "R1 ser_latch reset", ser_latch, 0);
        chk(done == 1'b0, "R1 done reset", done, 0);
        chk(req_ready == 1'b1, "R1 ready reset", req_ready, 1);

        // Directed corners: 18.25 dB example, extremes and clamping.
        send(8'd73, 3'd3, 1'b0);
        send(8'd0, 3'd0, 1'b0);
        send(8'd127, 3'd7, 1'b0);
        send(8'd128, 3'd2, 1'b0);
        send(8'd200, 3'd5, 1'b0);
        send(8'd255, 3'd1, 1'b0);
        send(8'h55, 3'd6, 1'b0);
        send(8'h2A, 3'd4, 1'b0);

        // Seeded random requests.
        for (int i = 0; i < 20; i++) begin
            send(8'($urandom_range(0, 255)), 3'($urandom_range(0, 7)), 1'b0);
        end

        // Pacing enabled, including back-to-back paced updates.
        send(8'd64, 3'd2, 1'b1);
        send(8'd31, 3'd7, 1'b1);
        send(8'd10, 3'd1, 1'b0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule